// File: doc/BRIEF.md
# Cache Block Refill Sequencer

After a cache miss, this block refills one 16-word cache block from main memory. A miss request arrives with a word address. The low four bits of that address are ignored, so the refill always covers the aligned block. The block spends one cycle driving the block address. It then runs the memory fetches and moves each fetched word, or group of words, across a shared bus into the cache data array through a write port. The CPU is held in stall from the address cycle through the last bus cycle.

The parameter `MODE` fixes the memory organization, and the sequencer is built once for that choice:

- **Mode 0:** one word-wide memory on a one-word bus.
- **Mode 1:** a four-word memory on a four-word bus.
- **Mode 2:** four one-word banks interleaved on a one-word bus.

Every memory access takes `LAT` cycles. Each bank has a holding register, so the next access starts in the same cycle that the previous result is on the bus. In mode 2 the banks start one cycle apart, and their transfers never collide.

The memory content is behavioural and computed. For word address `a` on 16 bits, the word is `{~a, a ^ 16'h5A3C}`. The block reports the measured miss penalty and pulses `done` once the refill completes.

Top module: `refill_seq`

## Requirements
- R1: One cycle after an accepted request, `addr_phase` is high for exactly one cycle.
- R2: `stall` is high from the address cycle through the cycle that carries the final bus transfer, and low otherwise.
- R3: At most one transfer occupies the bus in any cycle.
- R4: In mode 0, word i (0..15) is written in cycle 9+7i, counting the address cycle as cycle 1, with `fill_idx`=i.
- R5: In mode 1, transfer j (0..3) is written in cycle 9+7j with `fill_idx`=4j. `fill_data` carries words 4j..4j+3, with the lowest word in bits [31:0].
- R6: In mode 2, word 4j+k (bank k, round j) is written in cycle 9+7j+k with `fill_idx`=4j+k.
- R7: Each written word equals `{~a, a ^ 16'h5A3C}`, where `a` is the block base plus the word index, taken modulo 2^16.
- R8: `done` is high for exactly one cycle, the cycle after the final write, and `stall` is low in that cycle.
- R9: While `done` is high, `penalty` equals the number of cycles from the address cycle through the final transfer. With LAT=7 this is 114 in mode 0, 30 in mode 1 and 33 in mode 2.
- R10: A request is accepted only when neither `stall` nor `done` is high. Requests at other times cause no address cycle and do not change the data being refilled.
- R11: After reset, `stall`, `done`, `addr_phase` and `fill_we` are low.
- R12: `mem_addr` during the address cycle equals the request address with its low four bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| miss_req | input | 1 | Miss request, sampled only when the block is idle |
| miss_addr | input | AW | Word address of the miss |
| addr_phase | output | 1 | High during the address bus cycle |
| mem_addr | output | AW | Aligned block address |
| stall | output | 1 | Holds the CPU pipeline |
| fill_we | output | 1 | Cache array write strobe |
| fill_idx | output | 4 | Index of the first word written |
| fill_data | output | WPF*W | Written word(s), with the lowest index in the low bits |
| done | output | 1 | One-cycle completion pulse |
| penalty | output | 16 | Measured miss penalty in cycles |

## Verification
The bench predicts, for each mode, the exact cycle of every bus transfer and compares the data word by word. This catches a design that lets an access start one cycle late, that loses the overlap with the bus cycle (the penalty would grow), or that mis-staggers the banks (two transfers in one cycle, or the wrong index order). Addresses near the top of the address space and addresses with nonzero low bits test the wrap-around and alignment. Requests raised mid-refill, including one in the final bus cycle, target a design that restarts on a busy request. Such a design would show a second address cycle or data from the wrong block.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_FILL,
    ST_DONE
  } fill_state_t;

  localparam int BLOCK_WORDS = 16;
  localparam int IDX_W       = 4;
  localparam int PEN_W       = 16;
endpackage

// File: rtl/refill_mem.sv
// Behavioural memory: the content is computed from the address.
module refill_mem #(
  parameter int W   = 32,
  parameter int AW  = 16,
  parameter int WPF = 1
) (
  input  logic [AW-1:0]    addr,
  output logic [WPF*W-1:0] rdata
);
  localparam logic [AW-1:0] SALT = AW'(16'h5A3C);

  for (genvar w = 0; w < WPF; w++) begin : g_word
    logic [AW-1:0]   a;
    logic [2*AW-1:0] raw;
    assign a   = addr + AW'(w);
    assign raw = {~a, a ^ SALT};
    assign rdata[w*W +: W] = W'(raw);
  end
endmodule

// File: rtl/refill_bank.sv
// One fetch unit: runs ROUNDS accesses of LAT cycles each, back to back.
// The holding register presents each result for a single bus cycle
// while the next access is already running.
module refill_bank #(
  parameter int W       = 32,
  parameter int AW      = 16,
  parameter int WPF     = 1,
  parameter int LAT     = 7,
  parameter int ROUNDS  = 16,
  parameter int STRIDE  = 1,
  parameter int BANK_ID = 0,
  parameter int IDXW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    base,
  output logic             vld,
  output logic [WPF*W-1:0] data,
  output logic [IDXW-1:0]  widx
);
  localparam int CW = $clog2(LAT) + 1;
  localparam int RW = $clog2(ROUNDS) + 1;

  logic             busy_q, busy_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [RW-1:0]    rnd_q, rnd_n;
  logic             vld_q, vld_n;
  logic [WPF*W-1:0] hold_q, hold_n;
  logic [IDXW-1:0]  idx_q, idx_n;
  logic [AW-1:0]    fetch_addr;
  logic [WPF*W-1:0] mem_rd;

  // The address stays stable for the whole access because the round
  // number changes only when an access completes.
  assign fetch_addr = base + AW'(BANK_ID) + AW'(rnd_q) * AW'(STRIDE);

  refill_mem #(.W(W), .AW(AW), .WPF(WPF)) mem_i (
    .addr  (fetch_addr),
    .rdata (mem_rd)
  );

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    rnd_n  = rnd_q;
    vld_n  = 1'b0;
    hold_n = hold_q;
    idx_n  = idx_q;
    if (start) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      rnd_n  = '0;
    end else if (busy_q) begin
      if (cnt_q == CW'(LAT - 1)) begin
        vld_n  = 1'b1;
        hold_n = mem_rd;
        idx_n  = IDXW'(BANK_ID + int'(rnd_q) * STRIDE);
        cnt_n  = '0;
        if (rnd_q == RW'(ROUNDS - 1)) begin
          busy_n = 1'b0;
        end else begin
          rnd_n = rnd_q + 1'b1;
        end
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rnd_q  <= '0;
      vld_q  <= 1'b0;
      hold_q <= '0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      rnd_q  <= rnd_n;
      vld_q  <= vld_n;
      idx_q  <= idx_n;
      if (vld_n) begin
        hold_q <= hold_n;
      end
    end
  end

  assign vld  = vld_q;
  assign data = hold_q;
  assign widx = idx_q;
endmodule

// File: rtl/refill_seq.sv
module refill_seq
  import refill_pkg::*;
#(
  parameter int MODE = 2,   // 0: single word, 1: four-word wide, 2: four interleaved banks
  parameter int W    = 32,
  parameter int AW   = 16,
  parameter int LAT  = 7
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                miss_req,
  input  logic [AW-1:0]                       miss_addr,
  output logic                                addr_phase,
  output logic [AW-1:0]                       mem_addr,
  output logic                                stall,
  output logic                                fill_we,
  output logic [IDX_W-1:0]                    fill_idx,
  output logic [((MODE == 1) ? 4 : 1)*W-1:0]  fill_data,
  output logic                                done,
  output logic [PEN_W-1:0]                    penalty
);
  localparam int WPF    = (MODE == 1) ? 4 : 1;
  localparam int NB     = (MODE == 2) ? 4 : 1;
  localparam int STRIDE = NB * WPF;
  localparam int ROUNDS = BLOCK_WORDS / STRIDE;
  localparam int BUSW   = WPF * W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_i_n = rsync_q[1];

  fill_state_t      state_q, state_n;
  logic [AW-1:0]    base_q;
  logic [PEN_W-1:0] pen_q, pen_n;
  logic             accept;
  logic             last_xfer;
  logic             active;

  logic [NB-1:0]    bank_start;
  logic [NB-1:0]    bank_vld;
  logic [BUSW-1:0]  bank_data [NB];
  logic [IDX_W-1:0] bank_idx  [NB];

  assign active    = (state_q == ST_ADDR) || (state_q == ST_FILL);
  assign accept    = (state_q == ST_IDLE) && miss_req;
  assign last_xfer = fill_we && (fill_idx == IDX_W'(BLOCK_WORDS - WPF));

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)    state_n = ST_ADDR;
      ST_ADDR:                state_n = ST_FILL;
      ST_FILL: if (last_xfer) state_n = ST_DONE;
      ST_DONE:                state_n = ST_IDLE;
      default:                state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    pen_n = pen_q;
    if (accept) begin
      pen_n = '0;
    end else if (active) begin
      pen_n = pen_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      pen_q   <= '0;
    end else begin
      state_q <= state_n;
      pen_q   <= pen_n;
      if (accept) begin
        base_q <= {miss_addr[AW-1:IDX_W], {IDX_W{1'b0}}};
      end
    end
  end

  // Bank b is started in cycle b+1 of the refill, so its first
  // access begins one cycle after the one in bank b-1.
  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_start[b] = active && (pen_q == PEN_W'(b));

    refill_bank #(
      .W(W), .AW(AW), .WPF(WPF), .LAT(LAT), .ROUNDS(ROUNDS),
      .STRIDE(STRIDE), .BANK_ID(b), .IDXW(IDX_W)
    ) bank_i (
      .clk   (clk),
      .rst_n (rst_i_n),
      .start (bank_start[b]),
      .base  (base_q),
      .vld   (bank_vld[b]),
      .data  (bank_data[b]),
      .widx  (bank_idx[b])
    );
  end

  // Shared bus: the stagger leaves at most one bank valid per cycle.
  always_comb begin
    fill_data = '0;
    fill_idx  = '0;
    for (int b = 0; b < NB; b++) begin
      if (bank_vld[b]) begin
        fill_data = fill_data | bank_data[b];
        fill_idx  = fill_idx  | bank_idx[b];
      end
    end
  end

  assign fill_we    = |bank_vld;
  assign addr_phase = (state_q == ST_ADDR);
  assign mem_addr   = base_q;
  assign stall      = active;
  assign done       = (state_q == ST_DONE);
  assign penalty    = pen_q;
endmodule

// File: rtl/refill_seq_chk.sv
module refill_seq_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_phase,
  input logic          stall,
  input logic          fill_we,
  input logic          done,
  input logic [NB-1:0] bank_vld
);
  assert_addr_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> (!addr_phase && stall));

  assert_addr_in_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |-> stall);

  assert_write_in_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> stall);

  assert_bus_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_vld));

  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!stall && $past(fill_we)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !fill_we));

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !addr_phase) |=> !addr_phase);
endmodule

bind refill_seq refill_seq_chk #(.NB(NB)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_phase (addr_phase),
  .stall      (stall),
  .fill_we    (fill_we),
  .done       (done),
  .bank_vld   (bank_vld)
);

// File: tb/refill_seq_tb_top.sv
`timescale 1ns/1ps
module refill_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  int   n_chk  = 0;
  int   n_fail = 0;

  always #2.5 clk = ~clk;

  logic [2:0]  req;
  logic [15:0] addr [3];
  logic [2:0]  ap, st, we, dn;
  logic [15:0] ab [3];
  logic [15:0] pn [3];
  logic [3:0]  ix0, ix1, ix2;
  logic [31:0] d0, d2;
  logic [127:0] d1;

  refill_seq #(.MODE(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .miss_req(req[0]), .miss_addr(addr[0]),
    .addr_phase(ap[0]), .mem_addr(ab[0]), .stall(st[0]), .fill_we(we[0]),
    .fill_idx(ix0), .fill_data(d0), .done(dn[0]), .penalty(pn[0]));

  refill_seq #(.MODE(1)) dut_w_i (
    .clk(clk), .rst_n(rst_n), .miss_req(req[1]), .miss_addr(addr[1]),
    .addr_phase(ap[1]), .mem_addr(ab[1]), .stall(st[1]), .fill_we(we[1]),
    .fill_idx(ix1), .fill_data(d1), .done(dn[1]), .penalty(pn[1]));

  refill_seq #(.MODE(2)) dut_v_i (
    .clk(clk), .rst_n(rst_n), .miss_req(req[2]), .miss_addr(addr[2]),
    .addr_phase(ap[2]), .mem_addr(ab[2]), .stall(st[2]), .fill_we(we[2]),
    .fill_idx(ix2), .fill_data(d2), .done(dn[2]), .penalty(pn[2]));

  task automatic check(input bit ok, input string rq, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [15:0] a);
    return {~a, a ^ 16'h5A3C};
  endfunction

  // Cycle of each transfer, counting the address cycle as cycle 1.
  function automatic int slot_of(input int m, input int c);
    if (m == 2) begin
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 4; k++)
          if (c == 9 + 7*j + k) return 4*j + k;
      return -1;
    end
    if (c < 9 || (c - 9) % 7 != 0) return -1;
    if (m == 0) return ((c - 9) / 7 < 16) ? (c - 9) / 7 : -1;
    return ((c - 9) / 7 < 4) ? 4 * ((c - 9) / 7) : -1;
  endfunction

  function automatic int pen_of(input int m);
    return (m == 0) ? 9 + 7*15 : (m == 1) ? 9 + 7*3 : 9 + 7*3 + 3;
  endfunction

  function automatic logic [127:0] exp_data(input int m, input logic [15:0] b,
                                            input int s);
    logic [127:0] r = '0;
    if (m == 1) begin
      for (int w = 0; w < 4; w++) r[w*32 +: 32] = word_of(b + 16'(s + w));
    end else begin
      r[31:0] = word_of(b + 16'(s));
    end
    return r;
  endfunction

  function automatic logic [127:0] act_data(input int m);
    return (m == 0) ? {96'd0, d0} : (m == 1) ? d1 : {96'd0, d2};
  endfunction

  function automatic logic [3:0] act_idx(input int m);
    return (m == 0) ? ix0 : (m == 1) ? ix1 : ix2;
  endfunction

  // Runs one refill. inj > 0 raises a second request in that cycle.
  task automatic refill(input int m, input logic [15:0] a, input int inj);
    logic [15:0] b = a & 16'hFFF0;
    int p = pen_of(m);
    string rt = (m == 0) ? "R4" : (m == 1) ? "R5" : "R6";
    @(negedge clk);
    req[m]  = 1'b1;
    addr[m] = a;
    for (int c = 1; c <= p + 1; c++) begin
      @(negedge clk);
      if (c == 1) req[m] = 1'b0;
      if (c == inj) begin
        req[m] = 1'b1;
        addr[m] = ~a;
      end else if (c == inj + 1) begin
        req[m] = 1'b0;
      end
      check(ap[m] == (c == 1), "R1/R10 addr_phase", 128'(ap[m]), 128'(c == 1));
      if (c == 1) check(ab[m] == b, "R12 mem_addr", 128'(ab[m]), 128'(b));
      check(st[m] == (c <= p), "R2 stall", 128'(st[m]), 128'(c <= p));
      begin
        int s = slot_of(m, c);
        check(we[m] == (s >= 0), rt, 128'(we[m]), 128'(s >= 0));
        if (s >= 0) begin
          check(act_idx(m) == 4'(s), rt, 128'(act_idx(m)), 128'(s));
          check(act_data(m) == exp_data(m, b, s), "R7 data",
                act_data(m), exp_data(m, b, s));
        end
      end
      check(dn[m] == (c == p + 1), "R8 done", 128'(dn[m]), 128'(c == p + 1));
      if (c == p + 1) check(pn[m] == 16'(p), "R9 penalty", 128'(pn[m]), 128'(p));
    end
    @(negedge clk);
    check(ap[m] == 1'b0 && dn[m] == 1'b0 && st[m] == 1'b0, "R10 idle after",
          128'({ap[m], dn[m], st[m]}), 128'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd5150);
    req = '0;
    for (int m = 0; m < 3; m++) addr[m] = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 3; m++)
      check(st[m] == 0 && dn[m] == 0 && ap[m] == 0 && we[m] == 0, "R11 reset",
            128'({st[m], dn[m], ap[m], we[m]}), 128'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int m = 0; m < 3; m++)
      check(st[m] == 0 && dn[m] == 0 && ap[m] == 0 && we[m] == 0, "R11 post-reset",
            128'({st[m], dn[m], ap[m], we[m]}), 128'(0));

    // Directed corners: zero base, top-of-space wrap with unaligned low
    // bits, and a request during the final bus cycle (R10).
    for (int m = 0; m < 3; m++) begin
      refill(m, 16'h0000, 0);
      refill(m, 16'hFFF7, 5);
      refill(m, 16'h1234, pen_of(m));
    end

    for (int i = 0; i < 6; i++) begin
      for (int m = 0; m < 3; m++) begin
        logic [15:0] a = 16'($urandom);
        int inj = ($urandom % 2 == 1) ? 2 + int'($urandom % 20) : 0;
        repeat ($urandom % 4) @(negedge clk);
        refill(m, a, inj);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule